// File: doc/BRIEF.md
# Legacy Memory Steering Decoder

This block sits in a host bridge and decides, for every memory access below 1 MiB, where the access is sent. It holds a bank of shadow-attribute bytes and an SMRAM control byte in configuration space. From them it tells the fabric whether an access should be served by DRAM or passed on to the PCI/ROM side. Reads and writes are steered separately, so firmware can copy ROM into shadow RAM and then write-protect it.

The 128 KiB window from 0xA0000 to 0xBFFFF is also decoded. Normal masters and masters in system-management mode see this window in different ways, and a lock bit freezes that arrangement until reset. A read-only byte reports installed memory in 8 MiB units, saturated to 255.

Configuration goes through a byte-wide port. Queries are an address, a read/write flag and an SMM flag, and the steering outputs are combinational from them.

Top module: `legacy_mem_steer`

## Requirements
- R1: After reset, every attribute byte reads 0x00 and the SMRAM byte reads 0x02. Every access inside a shadow region or the SMRAM window then goes to PCI (to_pci=1, to_dram=0).
- R2: Attribute bytes sit at configuration offsets 0x59 to 0x5F and read back exactly what was written. Any offset that is not an attribute byte, 0x72 or 0x57 reads 0x00, and a write to it has no effect.
- R3: Region i takes its field from offset 0x59 + ceil(i/2). Odd regions use bits 3:0 of that byte. Region 0 and the even regions use bits 7:4.
- R4: In a region's field, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A clear bit sends that access type to PCI.
- R5: Region 0 spans 0xF0000 to 0xFFFFF. Region k (1 to 12) spans 16 KiB starting at 0xC0000 + (k-1)*0x4000, so the last one ends at 0xEFFFF.
- R6: The SMRAM byte at 0x72 holds open (bit 6), closed (bit 5), lock (bit 4) and global enable (bit 3). Bits 2:0 always read 010 and bit 7 always reads 0.
- R7: A write that sets lock stores open as 0. While lock is set, writes to 0x72 change nothing, until reset.
- R8: For a non-SMM access in 0xA0000 to 0xBFFFF, the target is DRAM when open is set and PCI otherwise. vis_ram_normal equals open.
- R9: For an SMM access in that window, the target is DRAM when global enable or open is set and PCI otherwise. vis_ram_smm reflects this.
- R10: A query made in the same cycle as a configuration write sees the old setting. The new setting applies from the next cycle.
- R11: Offset 0x57 reads min(ram_units, 255), sampled in the first cycle after reset. It ignores writes and any later change of ram_units.
- R12: An address outside every region and outside the SMRAM window asserts neither to_dram nor to_pci.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| ram_units | input | RAM_W | Installed memory in 8 MiB units |
| q_addr | input | AW | Query address |
| q_is_write | input | 1 | Query is a write |
| q_smm | input | 1 | Query comes from an SMM master |
| to_dram | output | 1 | Access is served by DRAM |
| to_pci | output | 1 | Access is forwarded to the PCI side |
| vis_ram_normal | output | 1 | SMRAM window shows RAM to non-SMM masters |
| vis_ram_smm | output | 1 | SMRAM window shows RAM to SMM masters |

## Verification
A configuration write and a steering query can fall in the same cycle, and the query may target the very region that the write reprograms. The bench provokes this by holding a query on a region address while it writes that region's attribute byte. It expects the old route during the write cycle and the new route in the following cycle. The same overlap is used on the SMRAM byte under lock, where the write must leave the route unchanged in both cycles.

// File: rtl/lms_pkg.sv
package lms_pkg;
   typedef struct packed {
      logic open;
      logic closed;
      logic lock;
      logic gen;
   } smram_ctl_t;

   localparam logic [2:0] SMRAM_FIXED = 3'b010;

   function automatic int half_up(input int v);
      return (v + 1) / 2;
   endfunction
endpackage

// File: rtl/lms_cfg_regs.sv
module lms_cfg_regs
   import lms_pkg::*;
#(
   parameter int NREG      = 13,
   parameter int ATTR_OFS  = 'h59,
   parameter int SMRAM_OFS = 'h72,
   parameter int HINT_OFS  = 'h57,
   parameter int RAM_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [7:0]         cfg_addr,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic [RAM_W-1:0]   ram_units,
   output logic [NREG*2-1:0]  region_attr,
   output smram_ctl_t         smram_ctl
);
   localparam int ATTR_BYTES = half_up(NREG - 1) + 1;

   if (RAM_W < 8) begin : g_bad_ramw
      $error("RAM_W must be at least 8");
   end
   if (ATTR_OFS + ATTR_BYTES > 256) begin : g_bad_ofs
      $error("attribute bytes exceed configuration space");
   end

   logic [7:0] attr_q [ATTR_BYTES];
   smram_ctl_t ctl_q;
   logic [7:0] hint_q;
   logic       init_q;

   for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            attr_q[b] <= '0;
         else if (cfg_we && cfg_addr == 8'(ATTR_OFS + b))
            attr_q[b] <= cfg_wdata;
      end
   end

   // region i -> byte ceil(i/2); odd regions low nibble, others high nibble
   for (genvar r = 0; r < NREG; r++) begin : g_map
      localparam int BYTE = half_up(r);
      if (r % 2 == 1) begin : g_lo
         assign region_attr[r*2 +: 2] = attr_q[BYTE][1:0];
      end else begin : g_hi
         assign region_attr[r*2 +: 2] = attr_q[BYTE][5:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (cfg_we && cfg_addr == 8'(SMRAM_OFS) && !ctl_q.lock) begin
         ctl_q.open   <= cfg_wdata[6] & ~cfg_wdata[4];
         ctl_q.closed <= cfg_wdata[5];
         ctl_q.lock   <= cfg_wdata[4];
         ctl_q.gen    <= cfg_wdata[3];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hint_q <= '0;
         init_q <= 1'b0;
      end else if (!init_q) begin
         hint_q <= (ram_units > RAM_W'(255)) ? 8'hFF : ram_units[7:0];
         init_q <= 1'b1;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < ATTR_BYTES; i++)
         if (cfg_addr == 8'(ATTR_OFS + i)) cfg_rdata = attr_q[i];
      if (cfg_addr == 8'(SMRAM_OFS))
         cfg_rdata = {1'b0, ctl_q.open, ctl_q.closed, ctl_q.lock, ctl_q.gen, SMRAM_FIXED};
      if (cfg_addr == 8'(HINT_OFS))
         cfg_rdata = hint_q;
   end

   assign smram_ctl = ctl_q;

   a_r2_attr_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 8'(ATTR_OFS)) |=> attr_q[0] == $past(cfg_wdata));
   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.lock |=> ctl_q.lock && $stable(ctl_q));
   a_r7_open_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.lock |-> !ctl_q.open);
   a_r11_hint_held: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> $stable(hint_q));
endmodule

// File: rtl/lms_region_decode.sv
module lms_region_decode #(
   parameter int AW         = 20,
   parameter int NREG       = 13,
   parameter int EXP_BASE   = 'hC0000,
   parameter int SEG_BYTES  = 'h4000,
   parameter int BIOS_BASE  = 'hF0000,
   parameter int BIOS_BYTES = 'h10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     q_addr,
   input  logic [NREG*2-1:0] region_attr,
   output logic              any_hit,
   output logic              rd_dram,
   output logic              wr_dram
);
   if (EXP_BASE + (NREG - 1) * SEG_BYTES > BIOS_BASE) begin : g_bad_map
      $error("expansion segments overlap the BIOS region");
   end
   if (BIOS_BASE + BIOS_BYTES > (1 << AW)) begin : g_bad_aw
      $error("BIOS region exceeds the address width");
   end

   logic [NREG-1:0] hit_vec;
   logic [AW:0]     addr_x;
   assign addr_x = {1'b0, q_addr};

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam int BASE = (r == 0) ? BIOS_BASE  : EXP_BASE + (r - 1) * SEG_BYTES;
      localparam int SIZE = (r == 0) ? BIOS_BYTES : SEG_BYTES;
      assign hit_vec[r] = (addr_x >= (AW+1)'(BASE)) && (addr_x < (AW+1)'(BASE + SIZE));
   end

   always_comb begin
      rd_dram = 1'b0;
      wr_dram = 1'b0;
      for (int r = 0; r < NREG; r++) begin
         if (hit_vec[r]) begin
            rd_dram = region_attr[r*2];
            wr_dram = region_attr[r*2+1];
         end
      end
   end

   assign any_hit = |hit_vec;

   a_r5_one_region: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/lms_smram_view.sv
module lms_smram_view
   import lms_pkg::*;
#(
   parameter int AW     = 20,
   parameter int WIN_LO = 'hA0000,
   parameter int WIN_HI = 'hBFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] q_addr,
   input  logic          q_smm,
   input  smram_ctl_t    ctl,
   output logic          in_win,
   output logic          win_dram,
   output logic          vis_normal,
   output logic          vis_smm
);
   if (WIN_LO > WIN_HI) begin : g_bad_win
      $error("SMRAM window bounds reversed");
   end

   assign in_win     = (q_addr >= AW'(WIN_LO)) && (q_addr <= AW'(WIN_HI));
   assign vis_normal = ctl.open;
   assign vis_smm    = ctl.open | ctl.gen;
   assign win_dram   = q_smm ? vis_smm : vis_normal;

   a_r9_smm_superset: assert property (@(posedge clk) disable iff (!rst_n)
      vis_normal |-> vis_smm);
endmodule

// File: rtl/legacy_mem_steer.sv
module legacy_mem_steer
   import lms_pkg::*;
#(
   parameter int AW         = 20,
   parameter int RAM_W      = 16,
   parameter int NUM_EXP    = 12,
   parameter int EXP_BASE   = 'hC0000,
   parameter int SEG_BYTES  = 'h4000,
   parameter int BIOS_BASE  = 'hF0000,
   parameter int BIOS_BYTES = 'h10000,
   parameter int WIN_LO     = 'hA0000,
   parameter int WIN_HI     = 'hBFFFF,
   parameter int ATTR_OFS   = 'h59,
   parameter int SMRAM_OFS  = 'h72,
   parameter int HINT_OFS   = 'h57
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [7:0]       cfg_addr,
   input  logic [7:0]       cfg_wdata,
   output logic [7:0]       cfg_rdata,
   input  logic [RAM_W-1:0] ram_units,
   input  logic [AW-1:0]    q_addr,
   input  logic             q_is_write,
   input  logic             q_smm,
   output logic             to_dram,
   output logic             to_pci,
   output logic             vis_ram_normal,
   output logic             vis_ram_smm
);
   localparam int NREG = NUM_EXP + 1;

   if (WIN_HI >= EXP_BASE) begin : g_bad_overlap
      $error("SMRAM window overlaps shadow regions");
   end

   logic [NREG*2-1:0] region_attr;
   smram_ctl_t        ctl;
   logic              any_hit, rd_dram, wr_dram;
   logic              in_win, win_dram;

   lms_cfg_regs #(
      .NREG(NREG), .ATTR_OFS(ATTR_OFS), .SMRAM_OFS(SMRAM_OFS),
      .HINT_OFS(HINT_OFS), .RAM_W(RAM_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_units(ram_units),
      .region_attr(region_attr), .smram_ctl(ctl)
   );

   lms_region_decode #(
      .AW(AW), .NREG(NREG), .EXP_BASE(EXP_BASE), .SEG_BYTES(SEG_BYTES),
      .BIOS_BASE(BIOS_BASE), .BIOS_BYTES(BIOS_BYTES)
   ) i_dec (
      .clk(clk), .rst_n(rst_n), .q_addr(q_addr), .region_attr(region_attr),
      .any_hit(any_hit), .rd_dram(rd_dram), .wr_dram(wr_dram)
   );

   lms_smram_view #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) i_win (
      .clk(clk), .rst_n(rst_n), .q_addr(q_addr), .q_smm(q_smm), .ctl(ctl),
      .in_win(in_win), .win_dram(win_dram),
      .vis_normal(vis_ram_normal), .vis_smm(vis_ram_smm)
   );

   logic region_dram;
   assign region_dram = q_is_write ? wr_dram : rd_dram;

   always_comb begin
      to_dram = 1'b0;
      to_pci  = 1'b0;
      if (in_win) begin
         to_dram = win_dram;
         to_pci  = ~win_dram;
      end else if (any_hit) begin
         to_dram = region_dram;
         to_pci  = ~region_dram;
      end
   end

   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_dram && to_pci));
   a_r8_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !q_smm && !vis_ram_normal) |-> to_pci);
   a_r1_covered: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win || any_hit) |-> (to_dram || to_pci));
endmodule

// File: tb/test_legacy_mem_steer.sv
`timescale 1ns/1ps
module test_legacy_mem_steer;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_we = 0;
   logic [7:0]  cfg_addr = 0;
   logic [7:0]  cfg_wdata = 0;
   logic [7:0]  cfg_rdata;
   logic [15:0] ram_units = 16'd300;
   logic [19:0] q_addr = 0;
   logic        q_is_write = 0;
   logic        q_smm = 0;
   logic        to_dram, to_pci, vis_ram_normal, vis_ram_smm;

   always #10 clk = ~clk;

   legacy_mem_steer i_legacy_mem_steer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_units(ram_units),
      .q_addr(q_addr), .q_is_write(q_is_write), .q_smm(q_smm),
      .to_dram(to_dram), .to_pci(to_pci),
      .vis_ram_normal(vis_ram_normal), .vis_ram_smm(vis_ram_smm)
   );

   typedef struct packed {
      logic       is_cfg;
      logic [7:0] rd;
      logic       dram;
      logic       pci;
      logic       vn;
      logic       vs;
   } item_t;

   item_t exp_q[$];
   string req_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   logic  e_vn = 0, e_vs = 0;

   // monitor: pops one expectation per cycle, away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         item_t it;
         string r;
         it = exp_q.pop_front();
         r  = req_q.pop_front();
         n_chk++;
         if (it.is_cfg) begin
            if (cfg_rdata !== it.rd) begin
               n_fail++;
               $display("FAIL %s: cfg_rdata=%02h expected %02h", r, cfg_rdata, it.rd);
            end
         end else if ({to_dram, to_pci, vis_ram_normal, vis_ram_smm} !==
                      {it.dram, it.pci, it.vn, it.vs}) begin
            n_fail++;
            $display("FAIL %s: dram/pci/vn/vs=%b%b%b%b expected %b%b%b%b", r,
                     to_dram, to_pci, vis_ram_normal, vis_ram_smm,
                     it.dram, it.pci, it.vn, it.vs);
         end
      end
   end

   task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic [19:0] qa, input logic qw, input logic qs);
      @(posedge clk); #1;
      cfg_we = we; cfg_addr = a; cfg_wdata = d;
      q_addr = qa; q_is_write = qw; q_smm = qs;
   endtask

   task automatic push_q(input logic ed, input logic ep, input string r);
      exp_q.push_back('{is_cfg: 1'b0, rd: 8'h00, dram: ed, pci: ep, vn: e_vn, vs: e_vs});
      req_q.push_back(r);
   endtask

   task automatic chk_q(input logic [19:0] qa, input logic qw, input logic qs,
                        input logic ed, input logic ep, input string r);
      step(0, 8'h00, 8'h00, qa, qw, qs);
      push_q(ed, ep, r);
   endtask

   task automatic chk_cfg(input logic [7:0] a, input logic [7:0] ev, input string r);
      step(0, a, 8'h00, 20'h0, 0, 0);
      exp_q.push_back('{is_cfg: 1'b1, rd: ev, dram: 1'b0, pci: 1'b0, vn: 1'b0, vs: 1'b0});
      req_q.push_back(r);
   endtask

   task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
      step(1, a, d, 20'h0, 0, 0);
   endtask

   initial begin
      #(20 * 20000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      repeat (2) @(posedge clk);

      // R1 reset state
      for (int i = 'h59; i <= 'h5F; i++) chk_cfg(8'(i), 8'h00, "R1 attr reset");
      chk_cfg(8'h72, 8'h02, "R1 smram reset");
      chk_q(20'hF0000, 0, 0, 0, 1, "R1 bios read to pci");
      chk_q(20'hC0000, 1, 0, 0, 1, "R1 seg write to pci");
      chk_q(20'hA0000, 0, 0, 0, 1, "R1 window to pci");
      // R11 hint saturates
      chk_cfg(8'h57, 8'hFF, "R11 hint clamp");
      // R12 outside
      chk_q(20'h50000, 0, 0, 0, 0, "R12 low memory");
      chk_q(20'h9FFFF, 1, 1, 0, 0, "R12 below window");

      // R4 read/write bits on region 0
      wr_cfg(8'h59, 8'h10);
      chk_q(20'hF1234, 0, 0, 1, 0, "R4 read bit");
      chk_q(20'hF1234, 1, 0, 0, 1, "R4 write clear");
      wr_cfg(8'h59, 8'h20);
      chk_q(20'hFFFFF, 0, 0, 0, 1, "R4 read clear");
      chk_q(20'hFFFFF, 1, 0, 1, 0, "R4 write bit");
      wr_cfg(8'h59, 8'h0F);
      chk_q(20'hF0000, 0, 0, 0, 1, "R3 region0 ignores low nibble");

      // R3 / R5 nibble and address mapping
      wr_cfg(8'h5A, 8'h31);
      chk_q(20'hC3FFF, 0, 0, 1, 0, "R3 region1 low nibble read");
      chk_q(20'hC3FFF, 1, 0, 0, 1, "R3 region1 low nibble write");
      chk_q(20'hC4000, 1, 0, 1, 0, "R5 region2 start");
      chk_q(20'hC8000, 0, 0, 0, 1, "R5 region3 unprogrammed");
      wr_cfg(8'h5F, 8'h02);
      chk_q(20'hE8000, 1, 0, 1, 0, "R3 region11 low nibble");
      chk_q(20'hEFFFF, 1, 0, 0, 1, "R3 region12 high nibble clear");
      wr_cfg(8'h5F, 8'h20);
      chk_q(20'hEFFFF, 1, 0, 1, 0, "R5 region12 end");
      chk_q(20'hEBFFF, 1, 0, 0, 1, "R5 region11 end");
      chk_cfg(8'h5A, 8'h31, "R2 readback");
      wr_cfg(8'h60, 8'h55);
      chk_cfg(8'h60, 8'h00, "R2 unmapped offset");

      // R10 same-cycle write and query
      step(1, 8'h5B, 8'h33, 20'hC8000, 0, 0);
      push_q(0, 1, "R10 old setting in write cycle");
      step(0, 8'h00, 8'h00, 20'hC8000, 0, 0);
      push_q(1, 0, "R10 new setting next cycle");
      chk_q(20'hCC000, 1, 0, 1, 0, "R3 region4 high nibble");

      // R6 / R8 / R9 SMRAM
      wr_cfg(8'h72, 8'hC7);
      chk_cfg(8'h72, 8'h42, "R6 fixed bits and bit7");
      e_vn = 1; e_vs = 1;
      chk_q(20'hA0000, 0, 0, 1, 0, "R8 open non-smm");
      chk_q(20'hBFFFF, 1, 1, 1, 0, "R9 open smm");
      wr_cfg(8'h72, 8'h08);
      e_vn = 0; e_vs = 1;
      chk_q(20'hB0000, 0, 0, 0, 1, "R8 closed non-smm");
      chk_q(20'hB0000, 1, 1, 1, 0, "R9 global enable smm");
      wr_cfg(8'h72, 8'h20);
      e_vn = 0; e_vs = 0;
      chk_cfg(8'h72, 8'h22, "R6 closed bit");
      chk_q(20'hA8000, 0, 1, 0, 1, "R9 no enable smm");

      // R7 lock
      wr_cfg(8'h72, 8'h58);
      e_vn = 0; e_vs = 1;
      chk_cfg(8'h72, 8'h1A, "R7 lock clears open");
      step(1, 8'h72, 8'h40, 20'hA0000, 0, 0);
      push_q(0, 1, "R7 locked write cycle");
      step(0, 8'h72, 8'h00, 20'hA0000, 0, 0);
      push_q(0, 1, "R7 locked after write");
      chk_cfg(8'h72, 8'h1A, "R7 locked readback");

      // R11 hint read-only and sampled once
      wr_cfg(8'h57, 8'h00);
      ram_units = 16'd5;
      chk_cfg(8'h57, 8'hFF, "R11 hint read-only");

      repeat (3) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule